// File: doc/BRIEF.md
# Variable-Length Instruction Aligner

This block sits between an instruction fetch buffer and the decoder. Fetched code arrives as 4-byte little-endian beats and is held in a small byte window. Each instruction is 16, 32, 48 or 64 bits long. The block works out the length from the 6-bit major opcode, using a fixed opcode-to-length map. It then hands the decoder one whole instruction per transfer, with its bytes rearranged into decode order.

In little-endian order the halfword that carries the major opcode is the one in window bytes 2 and 3, not bytes 0 and 1. A 16-bit instruction is lifted out of bytes 2–3 while bytes 0–1 stay at the head of the window. Longer instructions are read out halfword-swapped and consumed from the head of the window. Valid/ready handshakes sit on both sides, and a flush input discards everything the block holds.

Top module: `vlx_aligner`

## Requirements
- R1: After a synchronous reset, `out_valid` is 0 and `in_ready` is 1.
- R2: The major opcode is bits 7:2 of window byte 3. Opcodes 0 and 1 are 16-bit. Opcodes 2, 3, 56 and 57 are 48-bit. Opcodes 4, 5, 46 and 47 are 64-bit. All other opcodes are 32-bit. `out_len` encodes the length as 0=16, 1=32, 2=48, 3=64 bits.
- R3: `out_insn` places the instruction bytes in decode order from bits 63:56 downward, and every byte beyond the instruction's length is zero.
- R4: A 16-bit instruction is made of window bytes 2,3. Only those two bytes are removed. Bytes 0,1 stay at the head, and the old bytes 4,5 become the new bytes 2,3.
- R5: A 32-bit instruction is made of bytes 2,3,0,1, and those four bytes are consumed.
- R6: A 48-bit instruction is made of bytes 2,3,0,1,4,5, and those six bytes are consumed.
- R7: A 64-bit instruction is made of bytes 2,3,0,1,6,7,4,5, and those eight bytes are consumed.
- R8: `out_valid` rises only when the window held at least 4 bytes and at least the full classified length. The instruction appears on the cycle after it becomes complete and the output register is free.
- R9: An input beat carries byte k in `in_data[8k+7:8k]`. `in_ready` is 1 exactly when the window holds no more than DEPTH-4 bytes. A beat is accepted when `in_valid` and `in_ready` are both 1.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_insn` and `out_len` hold their values. At most one instruction leaves per cycle.
- R11: Asserting `flush` empties the window and clears `out_valid` on the next cycle. A beat offered in the same cycle as `flush` is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard window and pending output |
| in_valid | input | 1 | Fetch beat offered |
| in_ready | output | 1 | Window can take a beat |
| in_data | input | 32 | Four little-endian bytes |
| out_valid | output | 1 | Instruction available |
| out_ready | input | 1 | Decoder takes the instruction |
| out_len | output | 2 | Length code |
| out_insn | output | 64 | Instruction bytes in decode order, left-justified |

## Verification
The most likely internal faults are a wrong byte count in the window or a misplaced shift. If the count is wrong, the next classification reads the wrong byte 3, so the following instruction comes out with the wrong length and wrong bytes at once. It also disturbs `in_ready` in the same cycle, because that signal is derived only from the count. If the window keeps the wrong bytes after a 16-bit extraction, the damage shows on the next instruction, one transfer later. The bench compares a byte-queue model against the ports on every cycle, so the first wrong output is reported on the cycle it appears.

// File: rtl/vlx_pkg.sv
`timescale 1ns/1ps
package vlx_pkg;
  typedef enum logic [1:0] {
    LEN16 = 2'd0,
    LEN32 = 2'd1,
    LEN48 = 2'd2,
    LEN64 = 2'd3
  } ilen_e;

  function automatic logic [3:0] len_bytes(ilen_e l);
    case (l)
      LEN16:   return 4'd2;
      LEN48:   return 4'd6;
      LEN64:   return 4'd8;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/vlx_classify.sv
`timescale 1ns/1ps
module vlx_classify
  import vlx_pkg::*;
(
  input  logic [5:0] major,
  output ilen_e      len
);
  always_comb begin
    case (major)
      6'd0, 6'd1:                 len = LEN16;
      6'd2, 6'd3, 6'd56, 6'd57:   len = LEN48;
      6'd4, 6'd5, 6'd46, 6'd47:   len = LEN64;
      default:                    len = LEN32;
    endcase
  end
endmodule

// File: rtl/vlx_window.sv
`timescale 1ns/1ps
module vlx_window #(
  parameter int DEPTH = 12,
  parameter int BEAT  = 4,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                push,
  input  logic [BEAT*8-1:0]   push_data,
  input  logic                pop,
  input  logic [3:0]          pop_n,
  input  logic                pop_keep2,
  output logic [DEPTH*8-1:0]  bytes_o,
  output logic [CW-1:0]       count_o
);
  logic [7:0]    win [DEPTH];
  logic [7:0]    nxt [DEPTH];
  logic [CW-1:0] cnt, cnt_mid, cnt_nxt;

  always_comb begin
    cnt_mid = pop ? cnt - CW'(pop_n) : cnt;
    for (int i = 0; i < DEPTH; i++) begin
      int src;
      int rel;
      if (pop && !(pop_keep2 && i < 2)) src = i + int'(pop_n);
      else                              src = i;
      nxt[i] = (src < DEPTH) ? win[IW'(src)] : 8'h00;
      rel = i - int'(cnt_mid);
      if (push && rel >= 0 && rel < BEAT) nxt[i] = push_data[rel*8 +: 8];
    end
    cnt_nxt = push ? cnt_mid + CW'(BEAT) : cnt_mid;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) cnt <= '0;
    else              cnt <= cnt_nxt;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) win[i] <= nxt[i];
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_out
    assign bytes_o[g*8 +: 8] = win[g];
  end
  assign count_o = cnt;

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_pop_complete_R8: assert property (@(posedge clk) disable iff (rst || flush)
    pop |-> (cnt >= CW'(4)) && (CW'(pop_n) <= cnt));
endmodule

// File: rtl/vlx_pack.sv
`timescale 1ns/1ps
module vlx_pack
  import vlx_pkg::*;
(
  input  logic [63:0] b,
  input  ilen_e       len,
  output logic [63:0] insn
);
  logic [7:0] by [8];
  for (genvar g = 0; g < 8; g++) begin : g_by
    assign by[g] = b[g*8 +: 8];
  end

  always_comb begin
    insn = {by[2], by[3], by[0], by[1], 32'h0};
    case (len)
      LEN16:   insn = {by[2], by[3], 48'h0};
      LEN48:   insn[31:16] = {by[4], by[5]};
      LEN64:   insn[31:0]  = {by[6], by[7], by[4], by[5]};
      default: ;
    endcase
  end
endmodule

// File: rtl/vlx_aligner.sv
`timescale 1ns/1ps
module vlx_aligner
  import vlx_pkg::*;
#(
  parameter int DEPTH = 12,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        flush,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [1:0]  out_len,
  output logic [63:0] out_insn
);
  logic [DEPTH*8-1:0] win_bytes;
  logic [CW-1:0]      cnt;
  ilen_e              cls;
  logic [3:0]         need;
  logic [63:0]        packed_insn;
  logic               have, fire, push;

  vlx_window #(.DEPTH(DEPTH), .BEAT(4)) u_win (
    .clk(clk), .rst(rst), .flush(flush),
    .push(push), .push_data(in_data),
    .pop(fire), .pop_n(need), .pop_keep2(cls == LEN16),
    .bytes_o(win_bytes), .count_o(cnt)
  );

  vlx_classify u_cls (.major(win_bytes[31:26]), .len(cls));

  vlx_pack u_pack (.b(win_bytes[63:0]), .len(cls), .insn(packed_insn));

  assign need     = len_bytes(cls);
  assign have     = (cnt >= CW'(4)) && (cnt >= CW'(need));
  assign fire     = have && (!out_valid || out_ready) && !flush;
  assign in_ready = cnt <= CW'(DEPTH - 4);
  assign push     = in_valid && in_ready && !flush;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      out_valid <= 1'b0;
      out_len   <= 2'd0;
      out_insn  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_len   <= cls;
      out_insn  <= packed_insn;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst || flush)
    out_valid && !out_ready |=> out_valid && $stable(out_insn) && $stable(out_len));
  assert_flush_clear_R11: assert property (@(posedge clk) disable iff (rst)
    flush |=> !out_valid && in_ready);
  assert_short_zero_R3: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == LEN16 |-> out_insn[47:0] == 48'h0);
  assert_class16_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == LEN16 |-> out_insn[55:50] <= 6'd1);
  assert_class48_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_len == LEN48 |->
      (out_insn[55:50] inside {6'd2, 6'd3, 6'd56, 6'd57}));
endmodule

// File: tb/sim_vlx_aligner.sv
`timescale 1ns/1ps
module sim_vlx_aligner;
  localparam int DEPTH = 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        flush = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [1:0]  out_len;
  logic [63:0] out_insn;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  vlx_aligner #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_len(out_len), .out_insn(out_insn)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: byte queue plus output register
  logic [7:0]  mq[$];
  logic        mov = 1'b0;
  logic [1:0]  mlen = '0;
  logic [63:0] mins = '0;

  function automatic int cls_bytes(logic [5:0] op, output logic [1:0] code);
    if (op <= 1) begin code = 0; return 2; end
    if (op == 2 || op == 3 || op == 56 || op == 57) begin code = 2; return 6; end
    if (op == 4 || op == 5 || op == 46 || op == 47) begin code = 3; return 8; end
    code = 1; return 4;
  endfunction

  always @(posedge clk) begin
    if (rst || flush) begin
      mq.delete();
      mov = 1'b0;
    end else begin
      bit rdy;
      bit fired;
      rdy = (mq.size() <= DEPTH - 4);
      fired = 0;
      if (mq.size() >= 4) begin
        logic [1:0] code;
        int n;
        n = cls_bytes(mq[3][7:2], code);
        if (mq.size() >= n && (!mov || out_ready)) begin
          mins = {mq[2], mq[3], 48'h0};
          if (n >= 4) mins[47:32] = {mq[0], mq[1]};
          if (n == 6) mins[31:16] = {mq[4], mq[5]};
          if (n == 8) mins[31:0]  = {mq[6], mq[7], mq[4], mq[5]};
          mlen = code;
          mov = 1'b1;
          fired = 1;
          if (n == 2) begin mq.delete(3); mq.delete(2); end
          else for (int k = 0; k < n; k++) void'(mq.pop_front());
        end
      end
      if (!fired && out_ready) mov = 1'b0;
      if (in_valid && rdy)
        for (int k = 0; k < 4; k++) mq.push_back(in_data[k*8 +: 8]);
    end
  end

  // monitor, sampled mid-cycle
  logic        collect = 1'b0;
  logic [65:0] got[$];
  logic        p_ov = 1'b0, p_rdy = 1'b0, p_fl = 1'b0;
  logic [63:0] p_ins = '0;

  always @(negedge clk) begin
    #2;
    if (!rst) begin
      check("R9 in_ready", {63'h0, in_ready}, {63'h0, (mq.size() <= DEPTH - 4)});
      check("R8 out_valid", {63'h0, out_valid}, {63'h0, mov});
      if (mov && out_valid) begin
        string t;
        case (mlen)
          2'd0: t = "R4 16-bit";
          2'd1: t = "R5 32-bit";
          2'd2: t = "R6 48-bit";
          default: t = "R7 64-bit";
        endcase
        check({t, " len"}, {62'h0, out_len}, {62'h0, mlen});
        check({t, " insn"}, out_insn, mins);
      end
      if (p_ov && !p_rdy && !p_fl)
        check("R10 hold", out_insn, p_ins);
      if (collect && out_valid && out_ready) got.push_back({out_len, out_insn});
    end
    p_ov = out_valid; p_rdy = out_ready; p_fl = flush; p_ins = out_insn;
  end

  task automatic send(logic [31:0] d);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_flush();
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic expect_item(string tag, logic [1:0] l, logic [63:0] v);
    if (got.size() == 0) check({tag, " missing"}, 64'h0, {62'h0, l});
    else begin
      logic [65:0] e;
      e = got.pop_front();
      check({tag, " len"}, {62'h0, e[65:64]}, {62'h0, l});
      check({tag, " insn"}, e[63:0], v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    check("R1 out_valid", {63'h0, out_valid}, 64'h0);
    check("R1 in_ready", {63'h0, in_ready}, 64'h1);
    @(negedge clk);

    // directed mix: bytes listed as byte3..byte0 in each word
    collect = 1'b1;
    send(32'h0310BBAA);
    send(32'h0CEEDDCC);
    send(32'h1299E077);
    send(32'hBC030201);
    send(32'h08070605);
    send(32'h04232221);
    send(32'h14333231);
    repeat (6) @(negedge clk);
    collect = 1'b0;
    expect_item("R4 R2 R3 first", 2'd0, 64'h1003_0000_0000_0000);
    expect_item("R5 R4 after keep", 2'd1, 64'hCCDD_AABB_0000_0000);
    expect_item("R6 48-bit", 2'd2, 64'h77E0_EE0C_9912_0000);
    expect_item("R7 64-bit", 2'd3, 64'h03BC_0102_0708_0506);
    expect_item("R4 second", 2'd0, 64'h2304_0000_0000_0000);
    expect_item("R5 second", 2'd1, 64'h3132_2122_0000_0000);
    check("R8 no extra", {32'h0, 32'(got.size())}, 64'h0);

    // incomplete 64-bit instruction stays back; flush drops it
    do_flush();
    #2;
    check("R11 empty", {62'h0, out_valid, in_ready}, 64'h1);
    @(negedge clk);
    send(32'h10030201);
    repeat (4) @(negedge clk);
    #2;
    check("R8 partial held", {63'h0, out_valid}, 64'h0);
    @(negedge clk);
    do_flush();
    collect = 1'b1;
    send(32'h207C6B5A);
    repeat (4) @(negedge clk);
    collect = 1'b0;
    expect_item("R11 after flush", 2'd1, 64'h7C20_5A6B_0000_0000);
    check("R11 nothing stale", {32'h0, 32'(got.size())}, 64'h0);

    // backpressure fills the window
    do_flush();
    out_ready = 1'b0;
    in_valid = 1'b1;
    in_data = 32'h20111111;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    #2;
    check("R9 full window", {63'h0, in_ready}, 64'h0);
    check("R10 waiting", {63'h0, out_valid}, 64'h1);
    @(negedge clk);
    out_ready = 1'b1;
    repeat (6) @(negedge clk);
    do_flush();

    // random traffic against the reference model
    for (int c = 0; c < 5000; c++) begin
      in_valid  = ($urandom_range(0, 9) < 7);
      in_data   = $urandom;
      out_ready = ($urandom_range(0, 9) < 7);
      flush     = ($urandom_range(0, 299) == 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    flush = 1'b0;
    out_ready = 1'b1;
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule